// File: doc/BRIEF.md
# Register and Immediate Execute Unit

This unit is the execute stage for instructions that work only on registers or on a constant carried in the instruction word. Each issued operation supplies a 5-bit operation code, two 32-bit register values, the index of the destination register, and a 20-bit immediate field. One clock later the unit presents the 32-bit result and a write strobe for the register file. It also presents four condition flags: overflow, carry, zero and negative.

The unit covers four kinds of operation. The first is the four shifts. The second is the bitwise group: invert, AND, OR and exclusive OR. The third is register add and subtract. The fourth is the three immediate forms: load a signed constant, mask with a constant, and add a signed constant. Register 0 is hard-wired to zero. An operation aimed at it updates the flags but never raises the write strobe. Operation codes outside the supported set, and cycles with no issue, leave the flags alone and raise no write.

Top module: `reg_exec_unit`

## Requirements
- R1: The operation code selects as follows: 00001 load immediate, 00010 mask immediate, 00011 add immediate, 10000 shift left logical, 10001 rotate left, 10010 shift right logical, 10011 shift right arithmetic, 10100 invert A, 10101 A+B, 10110 A-B, 10111 A AND B, 11000 A OR B, 11001 A XOR B.
- R2: For the shifts and the rotate, the amount is bits 4:0 of B and the value shifted is A. The carry flag takes the last bit moved out: for the rotate, this is the bit that wrapped into bit 0. Carry is 0 when the amount is 0, and overflow is 0.
- R3: Invert, AND, OR and XOR clear both the carry flag and the overflow flag.
- R4: Add sets carry to the carry out of bit 31. Subtract sets carry to the inverse of the borrow, so carry is 1 when A >= B unsigned. Both set overflow on signed two's-complement overflow.
- R5: Load immediate produces the 20-bit field sign-extended to 32 bits, with carry and overflow cleared.
- R6: Mask immediate produces A AND the zero-extended field, so result bits 31:20 are always 0. Carry and overflow are cleared.
- R7: Add immediate produces A plus the sign-extended field, with carry and overflow set as for add.
- R8: For every supported operation, zero is set exactly when the result is 0, and negative equals result bit 31.
- R9: When the destination index is 0, the write strobe stays low, but the flags update as usual.
- R10: An unsupported operation code, or a cycle with the issue strobe low, raises no write and leaves all four flags unchanged.
- R11: Synchronous active-low reset clears the result, the write strobe and all flags.
- R12: Results, strobe and flags appear on the clock edge that follows the issue cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_vld | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code |
| dst_sel | input | 3 | Destination register index |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand, or shift amount in bits 4:0 |
| imm_fld | input | 20 | Immediate field |
| wb_data | output | 32 | Result |
| wb_en | output | 1 | Register file write strobe |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry, inverted borrow, or last bit shifted out |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |

## Verification
Some rules are checked by the assertions on every cycle:
- the write strobe stays low for destination 0, for unsupported codes and for idle cycles;
- the flags hold steady when no supported operation was issued;
- zero and negative agree with the registered result;
- overflow is clear after any bitwise or shift operation.

Other behaviour can only be shown by the bench's directed scenarios, because it depends on the arithmetic values:
- carry-versus-borrow polarity;
- the exact bit that leaves a shift or rotate;
- the use of only the low five bits of the shift amount;
- sign extension against zero extension of the immediate.

// File: rtl/reg_exec_pkg.sv
// Package: shared operation codes, flag bundle and decode helpers for the
// register/immediate execute unit. Assumes a 5-bit operation code.
package reg_exec_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OPC_LDIMM  = 5'b00001,
        OPC_MSKIMM = 5'b00010,
        OPC_ADDIMM = 5'b00011,
        OPC_SHL    = 5'b10000,
        OPC_ROL    = 5'b10001,
        OPC_SHR    = 5'b10010,
        OPC_SRA    = 5'b10011,
        OPC_INV    = 5'b10100,
        OPC_ADD    = 5'b10101,
        OPC_SUB    = 5'b10110,
        OPC_AND    = 5'b10111,
        OPC_IOR    = 5'b11000,
        OPC_XOR    = 5'b11001
    } opc_e;

    // Which execution path produces the result
    typedef enum logic [1:0] {
        PATH_SHIFT = 2'd0,
        PATH_LOGIC = 2'd1,
        PATH_ARITH = 2'd2,
        PATH_IMM   = 2'd3
    } path_e;

    typedef struct packed {
        logic v;
        logic c;
        logic z;
        logic n;
    } flags_t;

    // True for every operation code the unit executes
    function automatic logic opc_known(input logic [OPC_W-1:0] code);
        return (code >= 5'b00001 && code <= 5'b00011) ||
               (code >= 5'b10000 && code <= 5'b11001);
    endfunction

    // True for operations that force overflow to zero
    function automatic logic opc_no_ovf(input logic [OPC_W-1:0] code);
        return (code >= 5'b10000 && code <= 5'b10100) ||
               (code >= 5'b10111 && code <= 5'b11001) ||
               code == 5'b00001 || code == 5'b00010;
    endfunction

endpackage

// File: rtl/exec_shift_unit.sv
// Shift/rotate path: shifts A by a 5-bit amount in one of four styles and
// reports the last bit moved out. Assumes DATA_W is a power of two.
module exec_shift_unit #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [SH_W-1:0]   amt,
    input  logic [1:0]        style,   // 0 shl, 1 rol, 2 shr, 3 sra
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam logic [SH_W:0] DW_V = DATA_W[SH_W:0];

    logic [DATA_W:0] left_w;
    logic [DATA_W:0] right_w;
    logic [DATA_W:0] arith_w;
    logic [DATA_W-1:0] rot_v;
    logic [SH_W:0]     back_amt;

    // Form every shift variant with one guard bit that catches the exit bit
    always_comb begin
        left_w   = {1'b0, opnd} << amt;
        right_w  = {opnd, 1'b0} >> amt;
        arith_w  = DATA_W'(0) | ($signed({opnd, 1'b0}) >>> amt);
        back_amt = DW_V - {1'b0, amt};
        rot_v    = (opnd << amt) | (opnd >> back_amt);
    end

    // Pick the requested variant and its carry
    always_comb begin
        unique case (style)
            2'd0: begin res = left_w[DATA_W-1:0]; cout = left_w[DATA_W]; end
            2'd1: begin res = rot_v; cout = (amt != '0) && rot_v[0]; end
            2'd2: begin res = right_w[DATA_W:1]; cout = right_w[0]; end
            default: begin res = arith_w[DATA_W:1]; cout = arith_w[0]; end
        endcase
    end
endmodule

// File: rtl/exec_addsub_unit.sv
// Add/subtract path: two's-complement add or subtract with carry
// (inverted borrow on subtract) and signed overflow.
module exec_addsub_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ovf
);
    logic [DATA_W-1:0] b_eff;

    // Single adder with conditional inversion of B and carry-in
    always_comb begin
        b_eff       = sub ? ~b : b;
        {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        ovf         = (a[DATA_W-1] == b_eff[DATA_W-1]) &&
                      (sum[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/exec_logic_unit.sv
// Bitwise path: invert, AND, OR, XOR. No flag side effects here.
module exec_logic_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        fn,   // 0 inv, 1 and, 2 or, 3 xor
    output logic [DATA_W-1:0] res
);
    // Select the bitwise function
    always_comb begin
        unique case (fn)
            2'd0:    res = ~a;
            2'd1:    res = a & b;
            2'd2:    res = a | b;
            default: res = a ^ b;
        endcase
    end
endmodule

// File: rtl/reg_exec_unit.sv
// Top: decodes the operation code, routes operands to the shift, bitwise and
// add/subtract paths, and registers result, write strobe and flags one cycle
// after issue. Destination 0 suppresses the write only. Unsupported codes
// leave the flags unchanged.
module reg_exec_unit
    import reg_exec_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 20,
    parameter int RSEL_W  = 3,
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [4:0]        op_code,
    input  logic [RSEL_W-1:0] dst_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm_fld,
    output logic [DATA_W-1:0] wb_data,
    output logic              wb_en,
    output logic              flag_v,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx, imm_zx;
    logic [DATA_W-1:0] sh_res, lg_res, as_res, as_b, lg_b, nxt_res;
    logic              sh_c, as_c, as_v, as_sub;
    logic [1:0]        lg_fn;
    logic              known;
    path_e             path;
    flags_t            nxt_fl, fl_q;

    // Extend the immediate both ways
    always_comb begin
        imm_sx = {{PAD_W{imm_fld[IMM_W-1]}}, imm_fld};
        imm_zx = {{PAD_W{1'b0}}, imm_fld};
    end

    // Decode the operation code into a path and operand selects
    always_comb begin
        known  = opc_known(op_code);
        path   = PATH_IMM;
        as_sub = 1'b0;
        as_b   = src_b;
        lg_b   = src_b;
        lg_fn  = 2'd1;
        unique case (op_code)
            OPC_SHL, OPC_ROL, OPC_SHR, OPC_SRA: path = PATH_SHIFT;
            OPC_INV:    begin path = PATH_LOGIC; lg_fn = 2'd0; end
            OPC_AND:    begin path = PATH_LOGIC; lg_fn = 2'd1; end
            OPC_IOR:    begin path = PATH_LOGIC; lg_fn = 2'd2; end
            OPC_XOR:    begin path = PATH_LOGIC; lg_fn = 2'd3; end
            OPC_ADD:    path = PATH_ARITH;
            OPC_SUB:    begin path = PATH_ARITH; as_sub = 1'b1; end
            OPC_ADDIMM: begin path = PATH_ARITH; as_b = imm_sx; end
            OPC_MSKIMM: begin path = PATH_LOGIC; lg_b = imm_zx; end
            default:    path = PATH_IMM;
        endcase
    end

    exec_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .opnd  (src_a),
        .amt   (src_b[SH_W-1:0]),
        .style (op_code[1:0]),
        .res   (sh_res),
        .cout  (sh_c)
    );

    exec_logic_unit #(.DATA_W(DATA_W)) u_logic (
        .a   (src_a),
        .b   (lg_b),
        .fn  (lg_fn),
        .res (lg_res)
    );

    exec_addsub_unit #(.DATA_W(DATA_W)) u_addsub (
        .a    (src_a),
        .b    (as_b),
        .sub  (as_sub),
        .sum  (as_res),
        .cout (as_c),
        .ovf  (as_v)
    );

    // Merge the path outputs into the next result and flags
    always_comb begin
        nxt_fl = '0;
        unique case (path)
            PATH_SHIFT: begin nxt_res = sh_res; nxt_fl.c = sh_c; end
            PATH_LOGIC: nxt_res = lg_res;
            PATH_ARITH: begin nxt_res = as_res; nxt_fl.c = as_c; nxt_fl.v = as_v; end
            default:    nxt_res = imm_sx;
        endcase
        nxt_fl.z = (nxt_res == '0);
        nxt_fl.n = nxt_res[DATA_W-1];
    end

    // Register result, write strobe and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_data <= '0;
            wb_en   <= 1'b0;
            fl_q    <= '0;
        end else if (issue_vld && known) begin
            wb_data <= nxt_res;
            wb_en   <= (dst_sel != '0);
            fl_q    <= nxt_fl;
        end else begin
            wb_en   <= 1'b0;
        end
    end

    assign flag_v = fl_q.v;
    assign flag_c = fl_q.c;
    assign flag_z = fl_q.z;
    assign flag_n = fl_q.n;

    // R9
    r0_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && dst_sel == '0) |=> !wb_en);

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_vld && opc_known(op_code)) |=> (!wb_en && $stable(fl_q)));

    // R8
    zn_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && opc_known(op_code)) |=>
            (flag_z == (wb_data == '0) && flag_n == wb_data[DATA_W-1]));

    // R3
    bitwise_ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && opc_no_ovf(op_code)) |=> !flag_v);

    // R6
    mask_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && op_code == OPC_MSKIMM) |=> (wb_data[DATA_W-1:IMM_W] == '0));

    // R12
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && opc_known(op_code) && dst_sel != '0) |=> wb_en);
endmodule

// File: tb/sim_reg_exec_unit.sv
`timescale 1ns/1ps
module sim_reg_exec_unit;
    localparam logic [4:0] C_LDI = 5'b00001, C_MSK = 5'b00010, C_ADI = 5'b00011,
        C_SHL = 5'b10000, C_ROL = 5'b10001, C_SHR = 5'b10010, C_SRA = 5'b10011,
        C_INV = 5'b10100, C_ADD = 5'b10101, C_SUB = 5'b10110, C_AND = 5'b10111,
        C_IOR = 5'b11000, C_XOR = 5'b11001;

    logic clk = 1'b0, rst_n = 1'b0, issue_vld = 1'b0;
    logic [4:0] op_code = '0;
    logic [2:0] dst_sel = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [19:0] imm_fld = '0;
    logic [31:0] wb_data;
    logic wb_en, flag_v, flag_c, flag_z, flag_n;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    reg_exec_unit u0 (.clk(clk), .rst_n(rst_n), .issue_vld(issue_vld),
        .op_code(op_code), .dst_sel(dst_sel), .src_a(src_a), .src_b(src_b),
        .imm_fld(imm_fld), .wb_data(wb_data), .wb_en(wb_en), .flag_v(flag_v),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one operation, then sample one cycle later at the falling edge
    task automatic issue(input logic [4:0] c, input logic [2:0] d,
                         input logic [31:0] a, input logic [31:0] b, input logic [19:0] im);
        @(negedge clk);
        issue_vld = 1'b1; op_code = c; dst_sel = d; src_a = a; src_b = b; imm_fld = im;
        @(negedge clk);
        issue_vld = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [31:0] r, input logic en,
                              input logic [3:0] vczn);
        chk({tag, " data"}, wb_data, r);
        chk({tag, " wen"}, {31'd0, wb_en}, {31'd0, en});
        chk({tag, " flags"}, {28'd0, flag_v, flag_c, flag_z, flag_n}, {28'd0, vczn});
    endtask

    function automatic logic [3:0] zn(input logic [31:0] r, input logic v, input logic c);
        return {v, c, r == 32'd0, r[31]};
    endfunction

    // Reference shift: one bit per step, remembering the exiting bit
    function automatic logic [32:0] ref_shift(input logic [1:0] st, input logic [31:0] a, input int n);
        logic [31:0] x = a;
        logic c = 1'b0;
        for (int i = 0; i < n; i++) begin
            case (st)
                2'd0: begin c = x[31]; x = {x[30:0], 1'b0}; end
                2'd1: begin c = x[31]; x = {x[30:0], x[31]}; end
                2'd2: begin c = x[0]; x = {1'b0, x[31:1]}; end
                default: begin c = x[0]; x = {x[31], x[31:1]}; end
            endcase
        end
        return {c, x};
    endfunction

    task automatic t_reset();
        // R11
        expect_out("R11 reset", 32'd0, 1'b0, 4'b0000);
    endtask

    task automatic t_add_sub();
        // R4 R1
        issue(C_ADD, 3'd1, 32'h7fffffff, 32'd1, '0);
        expect_out("R4 add ovf", 32'h80000000, 1'b1, 4'b1001);
        issue(C_ADD, 3'd2, 32'hffffffff, 32'd1, '0);
        expect_out("R4 add carry", 32'd0, 1'b1, 4'b0110);
        issue(C_SUB, 3'd3, 32'd5, 32'd3, '0);
        expect_out("R4 sub noborrow", 32'd2, 1'b1, 4'b0100);
        issue(C_SUB, 3'd3, 32'd3, 32'd5, '0);
        expect_out("R4 sub borrow", 32'hfffffffe, 1'b1, 4'b0001);
        issue(C_SUB, 3'd4, 32'h80000000, 32'd1, '0);
        expect_out("R4 sub ovf", 32'h7fffffff, 1'b1, 4'b1100);
    endtask

    task automatic t_shifts();
        // R2 against a step-wise model, amount taken from B[4:0]
        logic [31:0] pats[4] = '{32'h80000001, 32'h8000000f, 32'h00000003, 32'hc3a5_5a3c};
        int amts[5] = '{0, 1, 4, 31, 33};
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [32:0] e;
                    e = ref_shift(2'(s), pats[p], amts[k] % 32);
                    issue(5'b10000 + 5'(s), 3'd5, pats[p], 32'(amts[k]), '0);
                    expect_out("R2 shift", e[31:0], 1'b1, zn(e[31:0], 1'b0, e[32]));
                end
            end
        end
        issue(C_ROL, 3'd1, 32'h80000000, 32'd1, '0);
        expect_out("R2 rol wrap", 32'd1, 1'b1, 4'b0100);
        issue(C_SRA, 3'd1, 32'h80000000, 32'd4, '0);
        expect_out("R2 sra sign", 32'hf8000000, 1'b1, 4'b0001);
    endtask

    task automatic t_logic();
        // R3: carry and overflow cleared even after a carry-setting add
        issue(C_ADD, 3'd1, 32'hffffffff, 32'h80000001, '0);
        issue(C_INV, 3'd1, 32'h0000ffff, 32'd0, '0);
        expect_out("R3 inv", 32'hffff0000, 1'b1, 4'b0001);
        issue(C_AND, 3'd1, 32'hf0f0f0f0, 32'h0f0f0f0f, '0);
        expect_out("R3 and zero", 32'd0, 1'b1, 4'b0010);
        issue(C_IOR, 3'd1, 32'h12000000, 32'h00000034, '0);
        expect_out("R3 or", 32'h12000034, 1'b1, 4'b0000);
        issue(C_XOR, 3'd1, 32'haaaaaaaa, 32'h5555aaaa, '0);
        expect_out("R3 xor", 32'hffff0000, 1'b1, 4'b0001);
    endtask

    task automatic t_immediates();
        // R5 R6 R7
        issue(C_LDI, 3'd2, 32'h12345678, 32'd0, 20'h80000);
        expect_out("R5 ldi neg", 32'hfff80000, 1'b1, 4'b0001);
        issue(C_LDI, 3'd2, 32'd0, 32'd0, 20'h7ffff);
        expect_out("R5 ldi pos", 32'h0007ffff, 1'b1, 4'b0000);
        issue(C_MSK, 3'd2, 32'hffffffff, 32'd0, 20'hfffff);
        expect_out("R6 mask", 32'h000fffff, 1'b1, 4'b0000);
        issue(C_ADI, 3'd2, 32'd10, 32'd0, 20'hfffff);
        expect_out("R7 addi minus1", 32'd9, 1'b1, 4'b0100);
        issue(C_ADI, 3'd2, 32'h7ffffff0, 32'd0, 20'h00010);
        expect_out("R7 addi ovf", 32'h80000000, 1'b1, 4'b1001);
    endtask

    task automatic t_dest_zero();
        // R9: no write strobe, flags follow the result
        issue(C_SUB, 3'd0, 32'd7, 32'd7, '0);
        expect_out("R9 dst0 sub", 32'd0, 1'b0, 4'b0110);
        issue(C_ADD, 3'd0, 32'h7fffffff, 32'd1, '0);
        expect_out("R9 dst0 add", 32'h80000000, 1'b0, 4'b1001);
    endtask

    task automatic t_ignored();
        // R10: set known flags, then unsupported codes and idle cycles
        issue(C_SUB, 3'd1, 32'd3, 32'd5, '0);
        expect_out("R10 setup", 32'hfffffffe, 1'b1, 4'b0001);
        issue(5'b00100, 3'd1, 32'd0, 32'd0, '0);
        expect_out("R10 code 4", 32'hfffffffe, 1'b0, 4'b0001);
        issue(5'b01100, 3'd1, 32'd0, 32'd0, '0);
        expect_out("R10 code 12", 32'hfffffffe, 1'b0, 4'b0001);
        issue(5'b11111, 3'd1, 32'd0, 32'd0, '0);
        expect_out("R10 code 31", 32'hfffffffe, 1'b0, 4'b0001);
        issue(5'b00000, 3'd1, 32'd0, 32'd0, '0);
        expect_out("R10 code 0", 32'hfffffffe, 1'b0, 4'b0001);
        @(negedge clk);
        op_code = C_ADD; src_a = 32'd0; src_b = 32'd0; dst_sel = 3'd1;
        @(negedge clk);
        expect_out("R10 idle", 32'hfffffffe, 1'b0, 4'b0001);
    endtask

    task automatic t_latency();
        // R12: output changes on the edge after issue, then strobe drops
        @(negedge clk);
        issue_vld = 1'b1; op_code = C_LDI; dst_sel = 3'd3; imm_fld = 20'h00005;
        #1;
        chk("R12 before edge", wb_data, 32'hfffffffe);
        @(negedge clk);
        issue_vld = 1'b0;
        chk("R12 after edge", wb_data, 32'd5);
        @(negedge clk);
        chk("R12 strobe drop", {31'd0, wb_en}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add_sub();
        t_shifts();
        t_logic();
        t_immediates();
        t_dest_zero();
        t_ignored();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule